// File: doc/BRIEF.md
# Bus idle cycle inserter

This block sits between a bus arbiter and an external memory interface. It enforces a programmable number of idle bus cycles between one access and the next. A single 32-bit configuration register holds a 3-bit idle code for each of seven memory areas and one more code for the device side of DMA transfers. The codes map to the idle counts 0, 1, 2, 3, 6, 9, 12 and 15.

When an access completes, the block records the area, direction and kind of that access. It loads a countdown with the idle count chosen for it. The count comes from the completed access's area code, or from the DMA code when the access was the device side of a DMA transfer. A pending request is then compared with the recorded access. If the two need a gap, the request's start strobe stays low until the countdown reaches zero. If they do not need a gap, the request starts at once. Multiplexed address/data accesses always get at least one idle cycle.

Top module: `bus_idle_gap`

## Requirements
- R1: An idle code c maps to the count 000→0, 001→1, 010→2, 011→3, 100→6, 101→9, 110→12, 111→15. When a gap is required, exactly that many cycles with `start` low lie between the cycle where `done_vld` is high and the cycle where `start` goes high.
- R2: Configuration field layout: the code of area n (n = 0..6) is in bits [3n+2:3n] and the DMA code is in bits [23:21]. Bits [31:24] read as zero. A cycle with `cfg_we` high loads `cfg_wdata`, and `cfg_rdata` shows the stored value from the next cycle on.
- R3: After reset `cfg_rdata` reads 32'h00FF_FFFF, which sets every code to 111.
- R4: When the pending request's area differs from the completed access's area, the gap is the completed access's count.
- R5: If the completed access was the device side of a DMA transfer (`done_dma_dev`=1), its count comes from the DMA code. Otherwise, including the memory side of a DMA transfer, the count comes from its area code.
- R6: For a request to the same area as the completed access, a read followed by a write gets the gap. A read followed by a read, or a write followed by anything, gets none, so `start` rises in the cycle right after `done_vld`.
- R7: A completed access with `done_mpx`=1 whose code is 000 still gets one idle cycle when a gap is required.
- R8: `start` is never high in a cycle where `done_vld` is high. With a zero count, `start` rises in the very next cycle.
- R9: Before any access has completed since reset, `start` equals `req_vld`.
- R10: A configuration write while a countdown runs leaves the loaded count unchanged. The new codes apply from the next completion on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| done_vld | input | 1 | The current access completes in this cycle |
| done_area | input | 3 | Area of the completing access (0..6) |
| done_write | input | 1 | Completing access is a write |
| done_dma_dev | input | 1 | Completing access is the device side of a DMA transfer |
| done_mpx | input | 1 | Completing access used multiplexed address/data |
| req_vld | input | 1 | A next access is pending |
| req_area | input | 3 | Area of the pending access |
| req_write | input | 1 | Pending access is a write |
| start | output | 1 | The pending access may start in this cycle |

## Verification
The assertions take for granted that `done_vld` is a single-cycle pulse and that areas are always 0 to 6. They also assume the arbiter holds a request stable until it sees `start`. The stimulus follows these rules: it pulses completion for exactly one cycle, draws areas modulo seven, and keeps the request fields fixed until the start strobe is observed. Configuration writes are placed either between transfers or at a chosen cycle inside a running countdown.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  localparam int AREA_W = 3;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic [AREA_W-1:0] area;
    logic              write;
    logic              dma_dev;
    logic              mpx;
  } acc_t;

  // Codes below four are linear; above, steps of three cycles.
  function automatic logic [CNT_W-1:0] code_to_cycles(input logic [CODE_W-1:0] c);
    int v;
    v = int'(c);
    if (v < 4) return CNT_W'(v);
    else       return CNT_W'(3 * v - 6);
  endfunction
endpackage

// File: rtl/idle_cfg_reg.sv
module idle_cfg_reg #(
  parameter int REG_W = 32,
  parameter int USED  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [USED-1:0]  fields
);
  logic [USED-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wdata[USED-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_nxt;
  end

  assign fields = q;
  assign rdata  = {{(REG_W-USED){1'b0}}, q};

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/idle_gap_rule.sv
module idle_gap_rule
  import bus_idle_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int USED      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [USED-1:0]   fields,
  input  logic              done_vld,
  input  acc_t              done_acc,
  input  acc_t              prev_acc,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  output logic [CNT_W-1:0]  load_cnt,
  output logic              gap_needed
);
  logic [CODE_W-1:0] area_code [NUM_AREAS];
  logic [CODE_W-1:0] dma_code;
  logic [CODE_W-1:0] sel_code;
  logic [CNT_W-1:0]  base_cnt;

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    assign area_code[g] = fields[g*CODE_W +: CODE_W];
  end
  assign dma_code = fields[NUM_AREAS*CODE_W +: CODE_W];

  always_comb begin
    sel_code = '0;
    if (done_acc.dma_dev) begin
      sel_code = dma_code;
    end else begin
      for (int i = 0; i < NUM_AREAS; i++)
        if (int'(done_acc.area) == i) sel_code = area_code[i];
    end
    base_cnt = code_to_cycles(sel_code);
    load_cnt = base_cnt;
    if (done_acc.mpx && base_cnt == '0) load_cnt = CNT_W'(1);
  end

  always_comb begin
    gap_needed = 1'b0;
    if (req_area != prev_acc.area)             gap_needed = 1'b1;
    else if (!prev_acc.write && req_write)     gap_needed = 1'b1;
  end

  // R7
  mpx_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && done_acc.mpx |-> load_cnt != '0);
endmodule

// File: rtl/idle_countdown.sv
module idle_countdown
  import bus_idle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  acc_t             load_acc,
  output logic [CNT_W-1:0] left,
  output acc_t             prev_acc,
  output logic             have_prev
);
  logic [CNT_W-1:0] left_nxt;
  acc_t             prev_nxt;
  logic             have_nxt;

  always_comb begin
    left_nxt = left;
    prev_nxt = prev_acc;
    have_nxt = have_prev;
    if (load) begin
      left_nxt = load_cnt;
      prev_nxt = load_acc;
      have_nxt = 1'b1;
    end else if (left != '0) begin
      left_nxt = left - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left      <= '0;
      prev_acc  <= '0;
      have_prev <= 1'b0;
    end else begin
      left      <= left_nxt;
      prev_acc  <= prev_nxt;
      have_prev <= have_nxt;
    end
  end

  // R1
  left_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && left != '0 |=> left == $past(left) - CNT_W'(1));
  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && left == '0 |=> left == '0);
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int REG_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              done_vld,
  input  logic [AREA_W-1:0] done_area,
  input  logic              done_write,
  input  logic              done_dma_dev,
  input  logic              done_mpx,
  input  logic              req_vld,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  output logic              start
);
  localparam int USED = (NUM_AREAS + 1) * CODE_W;

  logic             rst_m, rst_s;
  logic [USED-1:0]  fields;
  acc_t             done_acc, prev_acc;
  logic [CNT_W-1:0] load_cnt, left;
  logic             gap_needed, have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign done_acc = '{area: done_area, write: done_write,
                      dma_dev: done_dma_dev, mpx: done_mpx};

  idle_cfg_reg #(.REG_W(REG_W), .USED(USED)) u_cfg (
    .clk(clk), .rst_n(rst_s), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .fields(fields));

  idle_gap_rule #(.NUM_AREAS(NUM_AREAS), .USED(USED)) u_rule (
    .clk(clk), .rst_n(rst_s), .fields(fields), .done_vld(done_vld),
    .done_acc(done_acc), .prev_acc(prev_acc), .req_area(req_area),
    .req_write(req_write), .load_cnt(load_cnt), .gap_needed(gap_needed));

  idle_countdown u_cnt (
    .clk(clk), .rst_n(rst_s), .load(done_vld), .load_cnt(load_cnt),
    .load_acc(done_acc), .left(left), .prev_acc(prev_acc),
    .have_prev(have_prev));

  assign start = req_vld && !done_vld &&
                 (!have_prev || !gap_needed || left == '0);

  // R8
  start_vs_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done_vld |-> !start);
  // R10
  cfg_write_count_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_we && !done_vld && left != '0 |=> left == $past(left) - CNT_W'(1));
endmodule

// File: tb/bus_idle_gap_test.sv
`timescale 1ns/1ps
module bus_idle_gap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        done_vld = 1'b0;
  logic [2:0]  done_area = '0;
  logic        done_write = 1'b0, done_dma_dev = 1'b0, done_mpx = 1'b0;
  logic        req_vld = 1'b0;
  logic [2:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic        start;

  int compared = 0, mismatched = 0;
  logic [31:0] cfg_m;

  always #2 clk = ~clk;

  bus_idle_gap uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int map_code(input logic [2:0] c);
    case (c)
      3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 3;
      3'd4: return 6;  3'd5: return 9;  3'd6: return 12; default: return 15;
    endcase
  endfunction

  function automatic int exp_gap(input logic [31:0] cfg, input int pa, input bit pw,
                                 input bit pd, input bit pm, input int qa, input bit qw);
    int n;
    if (pa == qa && !(!pw && qw)) return 0;
    n = pd ? map_code(cfg[23:21]) : map_code(cfg[3*pa +: 3]);
    if (pm && n == 0) n = 1;
    return n;
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    cfg_m = v & 32'h00FF_FFFF;
  endtask

  // Completion then pending request; measures idle cycles before start.
  task automatic run_pair(input string tag, input int pa, input bit pw, input bit pd,
                          input bit pm, input int qa, input bit qw,
                          input int wr_at, input logic [31:0] wr_val);
    int k;
    int expg;
    expg = exp_gap(cfg_m, pa, pw, pd, pm, qa, qw);
    @(negedge clk);
    done_vld = 1'b1; done_area = 3'(pa); done_write = pw;
    done_dma_dev = pd; done_mpx = pm;
    req_vld = 1'b1; req_area = 3'(qa); req_write = qw;
    #1 check({tag, " R8 start during done"}, int'(start), 0);
    @(negedge clk);
    done_vld = 1'b0;
    k = 1;
    while (k < 25) begin
      if (k == wr_at) begin cfg_we = 1'b1; cfg_wdata = wr_val; end
      else cfg_we = 1'b0;
      #1;
      if (start) break;
      @(negedge clk);
      k++;
    end
    cfg_we = 1'b0;
    if (wr_at != 0) cfg_m = wr_val & 32'h00FF_FFFF;
    check(tag, k - 1, expg);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cfg_m = 32'h00FF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R3 reset value", int'(cfg_rdata), int'(32'h00FF_FFFF));

    // R9: no access completed yet
    @(negedge clk); req_vld = 1'b1; req_area = 3'd2; req_write = 1'b1;
    #1 check("R9 start before first access", int'(start), 1);
    @(negedge clk); req_vld = 1'b0;
    #1 check("R9 start follows req low", int'(start), 0);

    // R2 readback and reserved bits
    cfg_write(32'hFFFF_FFFF);
    #1 check("R2 reserved bits read zero", int'(cfg_rdata), int'(32'h00FF_FFFF));
    cfg_write(32'h0053_977A);
    #1 check("R2 readback", int'(cfg_rdata), int'(32'h0053_977A));

    // R1 every code value through area 3, different-area follow-up (R4)
    for (int c = 0; c < 8; c++) begin
      cfg_write(32'(c) << 9);
      run_pair("R1 R4 code map", 3, 1'b0, 1'b0, 1'b0, 5, 1'b0, 0, 0);
    end
    // R5 DMA device side uses DMA code, memory side uses area code
    cfg_write((32'd5 << 21) | (32'd2 << 3));
    run_pair("R5 dma device side", 1, 1'b1, 1'b1, 1'b0, 4, 1'b0, 0, 0);
    run_pair("R5 dma memory side", 1, 1'b1, 1'b0, 1'b0, 4, 1'b0, 0, 0);
    // R6 same-area ordering
    cfg_write(32'h00FF_FFFF);
    run_pair("R6 read->write same area", 6, 1'b0, 1'b0, 1'b0, 6, 1'b1, 0, 0);
    run_pair("R6 read->read same area", 6, 1'b0, 1'b0, 1'b0, 6, 1'b0, 0, 0);
    run_pair("R6 write->write same area", 6, 1'b1, 1'b0, 1'b0, 6, 1'b1, 0, 0);
    // R7 multiplexed access with zero code
    cfg_write(32'h0);
    run_pair("R7 mpx zero code", 0, 1'b0, 1'b0, 1'b1, 2, 1'b0, 0, 0);
    run_pair("R8 zero count next cycle", 0, 1'b0, 1'b0, 1'b0, 2, 1'b0, 0, 0);
    // R10 write during countdown
    cfg_write(32'h00FF_FFFF);
    run_pair("R10 count kept after write", 4, 1'b0, 1'b0, 1'b0, 1, 1'b1, 3, 32'h0);
    run_pair("R10 new code at next boundary", 4, 1'b0, 1'b0, 1'b0, 1, 1'b1, 0, 0);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      if (i % 10 == 0) cfg_write($urandom());
      run_pair("R4 R5 R6 R7 random", int'($urandom() % 7), 1'($urandom()), 1'($urandom()),
               1'($urandom()), int'($urandom() % 7), 1'($urandom()), 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule